// File: doc/BRIEF.md
# Capture-Compare Timer Status Logic

A 16-bit counting timer reached through an 8-bit register bus. A prescaler divides the clock by 2, 4 or 8, and each prescaler tick advances the counter by one. A rising edge on the capture input copies the counter into a capture register. A compare register is checked against the counter, and each match toggles the compare output pin. Three status flags record a counter wrap, a capture and a compare match. Software clears a flag in two steps. It first reads the status register while the flag is set. It then reads or writes the low byte of the data register that belongs to that flag. A second alias of the counter gives software a way to read the count without touching the wrap flag.

Each flag is held by its own small state machine with three states. `FLG_CLEAR` moves to `FLG_SET` when the flag's event occurs. `FLG_SET` moves to `FLG_ARMED` on a status read that has no event in the same cycle. `FLG_ARMED` returns to `FLG_CLEAR` on an access to the flag's low byte. `FLG_ARMED` falls back to `FLG_SET` if the event occurs again. If the event and the status read come in the same cycle, the event wins: the flag goes to (or stays in) `FLG_SET` and is not armed. Every other state stays where it is.

A disable bit in the status register stops the prescaler and the counter, and holds the compare pin low. While the timer is disabled, every register can still be read and written. Reading a counter high byte saves the low byte of that moment, so software gets a consistent 16-bit value from two byte reads.

Top module: `cct_timer`

## Requirements
- R1: After reset the status register reads 0x00 and the control register reads 0x00. The compare pin is 0 and the timer is enabled.
- R2: The prescaler select, control bits [1:0] at address 0, sets how often the counter steps: 00 steps it every 2 clocks, 01 every 4, and 10 or 11 every 8.
- R3: When the counter steps from 0xFFFF to 0x0000, the wrap flag (status bit 5) sets.
- R4: A flag clears after two accesses in order. The first is a status read (address 1) made while the flag is set. The second is a read or write of the flag's low byte: 3 for the counter, 7 for the capture, 9 for the compare. A low-byte access that no status read has armed leaves the flag set.
- R5: The counter alias (high byte at address 4, low byte at address 5) returns the counter value. Accessing it never clears the wrap flag.
- R6: A rising edge on `cap_pin` copies the counter into the capture register (high byte at address 6, low byte at address 7) and sets the capture flag (status bit 4).
- R7: When the counter steps to the value of the compare register (high byte at address 8, low byte at address 9), the compare flag (status bit 3) sets and `cmp_pin` toggles.
- R8: When the disable bit (status bit 2) is 1, the prescaler and counter hold their values and `cmp_pin` reads 0. Registers can still be read and written while the bit is 1.
- R9: If a flag's event occurs again after the arming status read, the next low-byte access does not clear the flag.
- R10: A read of a counter high byte (address 2 or 4) saves the low byte. The next read of the matching low byte returns that saved value even if the counter has moved on.
- R11: Status bits 7:6 and 1:0 read as 0. A status write changes only the disable bit. Only control bits [1:0] are stored; the other control bits read as 0.
- R12: A write to address 2 saves a pending high byte. A write to address 3 loads the counter with {pending high, written byte} and restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register, valid while bus_sel is 1 |
| cap_pin | input | 1 | Capture input, synchronous to clk, rising edge active |
| cmp_pin | output | 1 | Compare output; toggles on each match, 0 while disabled |

## Verification
The bench uses the default parameters: 8-bit data bus, 4-bit address and a 3-bit prescaler counter. With these, all four select codes, including the 11 code that saturates at divide-by-8, are counted over a fixed 40-clock window. Because the counter can be loaded, the bench can start it at 0xFFFE and see the wrap within a few cycles. The same load places the counter just below a compare value, so the bench can time the match to the exact cycle. The byte width also lets the bench test the saved low byte across a carry from 0x01FF to 0x0200.

// File: rtl/cct_pkg.sv
package cct_pkg;

    // Register addresses of the byte bus
    typedef enum logic [3:0] {
        RA_CTRL   = 4'd0,
        RA_STAT   = 4'd1,
        RA_CNT_HI = 4'd2,
        RA_CNT_LO = 4'd3,
        RA_ALT_HI = 4'd4,
        RA_ALT_LO = 4'd5,
        RA_CAP_HI = 4'd6,
        RA_CAP_LO = 4'd7,
        RA_CMP_HI = 4'd8,
        RA_CMP_LO = 4'd9
    } reg_addr_e;

    // Per-flag clearing state
    typedef enum logic [1:0] {
        FLG_CLEAR = 2'd0,
        FLG_SET   = 2'd1,
        FLG_ARMED = 2'd2
    } flag_state_e;

    // Flag slots
    localparam int NFLAG   = 3;
    localparam int IDX_OVF = 0;
    localparam int IDX_CAP = 1;
    localparam int IDX_CMP = 2;

    // Status bit positions
    localparam int SB_OVF = 5;
    localparam int SB_CAP = 4;
    localparam int SB_CMP = 3;
    localparam int SB_DIS = 2;

endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
    parameter int PRESC_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       clr_i,
    input  logic [1:0] sel_i,
    output logic       tick_o
);
    localparam int PW1 = PRESC_W + 1;

    logic [PRESC_W-1:0] pcnt_q;
    logic [1:0]         shift;
    logic [PW1-1:0]     div_w;
    logic [PW1-1:0]     div_m1_w;
    logic [PRESC_W-1:0] div_m1;

    always_comb begin
        shift    = (sel_i == 2'd3) ? 2'd2 : sel_i;
        div_w    = PW1'(2) << shift;
        div_m1_w = div_w - PW1'(1);
        div_m1   = div_m1_w[PRESC_W-1:0];
        tick_o   = run_i && (pcnt_q >= div_m1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (clr_i) begin
            pcnt_q <= '0;
        end else if (run_i) begin
            pcnt_q <= tick_o ? '0 : pcnt_q + 1'b1;
        end
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R8
    pres_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clr_i) |=> $stable(pcnt_q));

endmodule

// File: rtl/cct_flag_fsm.sv
module cct_flag_fsm
    import cct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic arm_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: begin
                if (set_i) state_d = FLG_SET;
            end
            FLG_SET: begin
                if (!set_i && arm_i) state_d = FLG_ARMED;
            end
            FLG_ARMED: begin
                if (set_i)      state_d = FLG_SET;
                else if (clr_i) state_d = FLG_CLEAR;
            end
            default: state_d = FLG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        flag_o = (state_q != FLG_CLEAR);
    end

    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && state_q != FLG_ARMED) |=> flag_o);

    // R9
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLG_ARMED && set_i) |=> (flag_o && state_q != FLG_ARMED));

endmodule

// File: rtl/cct_read_latch.sv
module cct_read_latch #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*BYTE_W-1:0] live_i,
    input  logic                rd_hi_i,
    input  logic                rd_lo_i,
    output logic [BYTE_W-1:0]   hi_o,
    output logic [BYTE_W-1:0]   lo_o
);
    logic [BYTE_W-1:0] held_q;
    logic              valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q  <= '0;
            valid_q <= 1'b0;
        end else if (rd_hi_i) begin
            held_q  <= live_i[BYTE_W-1:0];
            valid_q <= 1'b1;
        end else if (rd_lo_i) begin
            valid_q <= 1'b0;
        end
    end

    always_comb begin
        hi_o = live_i[2*BYTE_W-1:BYTE_W];
        lo_o = valid_q ? held_q : live_i[BYTE_W-1:0];
    end

    // R10
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi_i |=> (lo_o == $past(live_i[BYTE_W-1:0])));

endmodule

// File: rtl/cct_timer.sv
module cct_timer
    import cct_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 4,
    parameter int PRESC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cap_pin,
    output logic              cmp_pin
);
    localparam int CNT_W = 2 * DATA_W;

    reg_addr_e         addr_e;
    logic              rd_acc;
    logic              wr_acc;

    logic              dis_q;
    logic [1:0]        psel_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_inc;
    logic [DATA_W-1:0] hi_buf_q;
    logic [CNT_W-1:0]  cmp_q;
    logic [CNT_W-1:0]  cap_q;
    logic              cap_prev_q;
    logic              tog_q;

    logic              load;
    logic              tick;
    logic              ovf_evt;
    logic              cmp_evt;
    logic              cap_evt;
    logic              stat_rd;

    logic [NFLAG-1:0]  flag_set;
    logic [NFLAG-1:0]  flag_clr;
    logic [NFLAG-1:0]  flag_v;

    logic [DATA_W-1:0] cnt_hi_b, cnt_lo_b, alt_hi_b, alt_lo_b;
    logic [DATA_W-1:0] stat_b, ctrl_b;

    always_comb begin
        addr_e  = reg_addr_e'(bus_addr);
        rd_acc  = bus_sel && !bus_wr;
        wr_acc  = bus_sel && bus_wr;
        load    = wr_acc && (addr_e == RA_CNT_LO);
        stat_rd = rd_acc && (addr_e == RA_STAT);
        cnt_inc = cnt_q + 1'b1;
        ovf_evt = tick && !load && (cnt_q == '1);
        cmp_evt = tick && !load && (cnt_inc == cmp_q);
        cap_evt = cap_pin && !cap_prev_q;
    end

    cct_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (!dis_q),
        .clr_i  (load),
        .sel_i  (psel_q),
        .tick_o (tick)
    );

    // Control, disable bit and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dis_q    <= 1'b0;
            psel_q   <= 2'd0;
            cnt_q    <= '0;
            hi_buf_q <= '0;
            cmp_q    <= '1;
            cap_prev_q <= 1'b0;
            tog_q    <= 1'b0;
        end else begin
            cap_prev_q <= cap_pin;
            if (wr_acc && addr_e == RA_STAT) dis_q  <= bus_wdata[SB_DIS];
            if (wr_acc && addr_e == RA_CTRL) psel_q <= bus_wdata[1:0];
            if (wr_acc && addr_e == RA_CNT_HI) hi_buf_q <= bus_wdata;
            if (wr_acc && addr_e == RA_CMP_HI) cmp_q[CNT_W-1:DATA_W] <= bus_wdata;
            if (wr_acc && addr_e == RA_CMP_LO) cmp_q[DATA_W-1:0] <= bus_wdata;
            if (load)      cnt_q <= {hi_buf_q, bus_wdata};
            else if (tick) cnt_q <= cnt_inc;
            if (cmp_evt)   tog_q <= !tog_q;
        end
    end

    // Capture register: no reset, value is undefined until the first capture
    always_ff @(posedge clk) begin
        if (cap_evt) cap_q <= cnt_q;
    end

    // Flag state machines
    always_comb begin
        flag_set[IDX_OVF] = ovf_evt;
        flag_set[IDX_CAP] = cap_evt;
        flag_set[IDX_CMP] = cmp_evt;
        flag_clr[IDX_OVF] = bus_sel && (addr_e == RA_CNT_LO);
        flag_clr[IDX_CAP] = bus_sel && (addr_e == RA_CAP_LO);
        flag_clr[IDX_CMP] = bus_sel && (addr_e == RA_CMP_LO);
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        cct_flag_fsm u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[g]),
            .arm_i  (stat_rd),
            .clr_i  (flag_clr[g]),
            .flag_o (flag_v[g])
        );
    end

    // Coherent byte reads: main counter and alias
    cct_read_latch #(.BYTE_W(DATA_W)) u_cnt_rl (
        .clk     (clk),
        .rst_n   (rst_n),
        .live_i  (cnt_q),
        .rd_hi_i (rd_acc && addr_e == RA_CNT_HI),
        .rd_lo_i (rd_acc && addr_e == RA_CNT_LO),
        .hi_o    (cnt_hi_b),
        .lo_o    (cnt_lo_b)
    );

    cct_read_latch #(.BYTE_W(DATA_W)) u_alt_rl (
        .clk     (clk),
        .rst_n   (rst_n),
        .live_i  (cnt_q),
        .rd_hi_i (rd_acc && addr_e == RA_ALT_HI),
        .rd_lo_i (rd_acc && addr_e == RA_ALT_LO),
        .hi_o    (alt_hi_b),
        .lo_o    (alt_lo_b)
    );

    // Read mux and outputs
    always_comb begin
        stat_b         = '0;
        stat_b[SB_OVF] = flag_v[IDX_OVF];
        stat_b[SB_CAP] = flag_v[IDX_CAP];
        stat_b[SB_CMP] = flag_v[IDX_CMP];
        stat_b[SB_DIS] = dis_q;
        ctrl_b         = '0;
        ctrl_b[1:0]    = psel_q;
        bus_rdata      = '0;
        if (bus_sel) begin
            unique case (addr_e)
                RA_CTRL:   bus_rdata = ctrl_b;
                RA_STAT:   bus_rdata = stat_b;
                RA_CNT_HI: bus_rdata = cnt_hi_b;
                RA_CNT_LO: bus_rdata = cnt_lo_b;
                RA_ALT_HI: bus_rdata = alt_hi_b;
                RA_ALT_LO: bus_rdata = alt_lo_b;
                RA_CAP_HI: bus_rdata = cap_q[CNT_W-1:DATA_W];
                RA_CAP_LO: bus_rdata = cap_q[DATA_W-1:0];
                RA_CMP_HI: bus_rdata = cmp_q[CNT_W-1:DATA_W];
                RA_CMP_LO: bus_rdata = cmp_q[DATA_W-1:0];
                default:   bus_rdata = '0;
            endcase
        end
        cmp_pin = tog_q && !dis_q;
    end

    // R3
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt_q == '1) |=> (flag_v[IDX_OVF] && cnt_q == '0));

    // R8
    frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q && !load) |=> $stable(cnt_q));

    // R5
    alt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_v[IDX_OVF] && bus_sel && (addr_e == RA_ALT_LO || addr_e == RA_ALT_HI))
        |=> flag_v[IDX_OVF]);

    // R11
    stat_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && addr_e == RA_STAT) |-> (bus_rdata[1:0] == 2'b00 && bus_rdata[7:6] == 2'b00));

    // R6
    cap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_q == $past(cnt_q) && flag_v[IDX_CAP]));

    // R7
    cmp_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt |=> (tog_q != $past(tog_q)));

endmodule

// File: tb/cct_timer_tb.sv
module cct_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cap_pin = 1'b0;
    logic       cmp_pin;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cct_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_pin   (cap_pin),
        .cmp_pin   (cmp_pin)
    );

    // Addresses
    localparam logic [3:0] A_CTRL = 4'd0, A_STAT = 4'd1, A_CNTH = 4'd2, A_CNTL = 4'd3,
                           A_ALTH = 4'd4, A_ALTL = 4'd5, A_CAPH = 4'd6, A_CAPL = 4'd7,
                           A_CMPH = 4'd8, A_CMPL = 4'd9;
    // Ops
    localparam logic [3:0] OP_WR = 4'd0, OP_RD = 4'd1, OP_RDX = 4'd2, OP_IDLE = 4'd3;

    // {op, addr, data, expected, requirement number}
    localparam int NV = 25;
    localparam logic [31:0] VEC [NV] = '{
        {OP_RD,   A_STAT, 8'h00, 8'h00, 8'd1},   // R1 status after reset
        {OP_RD,   A_CTRL, 8'h00, 8'h00, 8'd1},   // R1 control after reset
        {OP_WR,   A_STAT, 8'h04, 8'h00, 8'd8},   // R8 disable
        {OP_RD,   A_STAT, 8'h00, 8'h04, 8'd11},  // R11 disable bit position
        {OP_WR,   A_CMPH, 8'h80, 8'h00, 8'd7},
        {OP_WR,   A_CMPL, 8'h00, 8'h00, 8'd7},
        {OP_WR,   A_CNTH, 8'hFF, 8'h00, 8'd12},  // R12 pending high
        {OP_WR,   A_CNTL, 8'hFE, 8'h00, 8'd12},  // R12 load 0xFFFE
        {OP_IDLE, 4'd0,   8'd8,  8'h00, 8'd8},
        {OP_RD,   A_CNTH, 8'h00, 8'hFF, 8'd8},   // R8 frozen while disabled
        {OP_RD,   A_CNTL, 8'h00, 8'hFE, 8'd12},  // R12 loaded value
        {OP_RD,   A_ALTH, 8'h00, 8'hFF, 8'd5},   // R5 alias value
        {OP_RD,   A_ALTL, 8'h00, 8'hFE, 8'd5},
        {OP_WR,   A_STAT, 8'h00, 8'h00, 8'd8},   // enable
        {OP_IDLE, 4'd0,   8'd6,  8'h00, 8'd3},
        {OP_RD,   A_STAT, 8'h00, 8'h20, 8'd3},   // R3 wrap flag, arms
        {OP_RDX,  A_ALTL, 8'h00, 8'h00, 8'd5},
        {OP_RD,   A_STAT, 8'h00, 8'h20, 8'd5},   // R5 alias left flag set
        {OP_RDX,  A_CNTL, 8'h00, 8'h00, 8'd4},
        {OP_RD,   A_STAT, 8'h00, 8'h00, 8'd4},   // R4 cleared by low-byte read
        {OP_WR,   A_STAT, 8'h04, 8'h00, 8'd8},
        {OP_WR,   A_STAT, 8'hFF, 8'h00, 8'd11},
        {OP_RD,   A_STAT, 8'h00, 8'h04, 8'd11},  // R11 only disable writable
        {OP_WR,   A_CTRL, 8'hFF, 8'h00, 8'd11},
        {OP_RD,   A_CTRL, 8'h00, 8'h03, 8'd11}   // R11 control upper bits zero
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Tasks start and end at a falling edge
    task automatic bwr(input logic [3:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [3:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cmp_pin after reset", {7'd0, cmp_pin}, 8'h00);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [3:0] op, a;
            logic [7:0] dat, ex, rq;
            {op, a, dat, ex, rq} = VEC[i];
            case (op)
                OP_WR:   bwr(a, dat);
                OP_IDLE: idle(int'(dat));
                OP_RDX:  brd(a, d);
                default: begin
                    brd(a, d);
                    chk($sformatf("R%0d vector %0d", rq, i), d, ex);
                end
            endcase
        end

        // R2 prescaler ratios over a 40-clock window
        for (int s = 0; s < 4; s++) begin
            logic [7:0] ex;
            ex = (s == 0) ? 8'd20 : (s == 1) ? 8'd10 : 8'd5;
            bwr(A_CTRL, 8'(s));
            bwr(A_CNTH, 8'h00);
            bwr(A_CNTL, 8'h00);
            bwr(A_STAT, 8'h00);
            idle(39);
            bwr(A_STAT, 8'h04);
            brd(A_CNTH, d);
            chk($sformatf("R2 sel %0d high", s), d, 8'h00);
            brd(A_CNTL, d);
            chk($sformatf("R2 sel %0d count", s), d, ex);
        end
        bwr(A_CTRL, 8'h00);

        // R10 saved low byte across a carry
        bwr(A_CNTH, 8'h01);
        bwr(A_CNTL, 8'hFE);
        bwr(A_STAT, 8'h00);
        brd(A_CNTH, d);
        chk("R10 high byte", d, 8'h01);
        idle(4);
        brd(A_CNTL, d);
        chk("R10 saved low byte", d, 8'hFE);
        bwr(A_STAT, 8'h04);

        // R6 capture while frozen at 0x1234
        bwr(A_CNTH, 8'h12);
        bwr(A_CNTL, 8'h34);
        cap_pin = 1'b1;
        idle(1);
        brd(A_STAT, d);
        chk("R6 capture flag", d, 8'h14);
        brd(A_CAPH, d);
        chk("R6 capture high", d, 8'h12);
        brd(A_CAPL, d);
        chk("R6 capture low", d, 8'h34);
        brd(A_STAT, d);
        chk("R4 capture flag cleared", d, 8'h04);

        // R4 unarmed access, R9 re-set after arming
        cap_pin = 1'b0; idle(1);
        cap_pin = 1'b1; idle(1);
        brd(A_CAPL, d);
        brd(A_STAT, d);
        chk("R4 unarmed low read keeps flag", d, 8'h14);
        cap_pin = 1'b0; idle(1);
        cap_pin = 1'b1; idle(1);
        brd(A_CAPL, d);
        brd(A_STAT, d);
        chk("R9 re-set flag survives low read", d, 8'h14);
        brd(A_CAPL, d);
        brd(A_STAT, d);
        chk("R4 armed low read clears", d, 8'h04);

        // R7 compare match, R8 pin forcing
        bwr(A_CMPH, 8'h00);
        bwr(A_CMPL, 8'h10);
        bwr(A_CNTH, 8'h00);
        bwr(A_CNTL, 8'h0E);
        chk("R8 pin low while disabled", {7'd0, cmp_pin}, 8'h00);
        bwr(A_STAT, 8'h00);
        idle(1);
        chk("R7 no toggle before match", {7'd0, cmp_pin}, 8'h00);
        idle(2);
        chk("R7 no toggle one step early", {7'd0, cmp_pin}, 8'h00);
        idle(1);
        chk("R7 pin toggled on match", {7'd0, cmp_pin}, 8'h01);
        bwr(A_STAT, 8'h04);
        chk("R8 pin forced low", {7'd0, cmp_pin}, 8'h00);
        brd(A_STAT, d);
        chk("R7 compare flag", d, 8'h0C);
        brd(A_CNTH, d);
        chk("R8 frozen high", d, 8'h00);
        brd(A_CNTL, d);
        chk("R8 frozen low", d, 8'h10);
        bwr(A_CMPL, 8'h10);
        brd(A_STAT, d);
        chk("R4 armed low write clears", d, 8'h04);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

endmodule